// File: doc/BRIEF.md
# Pointer-Register Memory Address Generator

This block forms data-memory addresses for indirect, displacement and direct loads and stores in a small 8-bit processor core. It receives a request that has already been decoded: which pointer to use, the addressing mode, a 6-bit offset, a 16-bit immediate, the transfer direction and the destination register of a load. The three 16-bit pointers sit in the top six bytes of a 32-entry byte register file. Their current values arrive on input ports, and the block returns the updated pointer as two byte writes.

Every accepted request takes two cycles. In the first cycle the block raises `busy` so that the pipeline stalls, and it drives the memory strobe and the address. In the second cycle it issues the pointer write-back and the enable for writing the loaded byte into the register file. A new request can be accepted in that second cycle, so back-to-back accesses run at one every two cycles.

Top module: `ptr_addr_gen`

## Requirements
- R1: Pointer select 0 uses register pair 27:26, select 1 uses 29:28, and select 2 or 3 uses 31:30. The odd, higher-numbered register carries the high byte. A write-back drives `ptr_lo_idx` with the even register and `ptr_hi_idx` with the odd one.
- R2: Mode 0 (plain indirect), and the unused mode codes 5 to 7, access the address held in the pointer and leave the pointer unchanged, so `ptr_we` stays low.
- R3: Mode 1 (post-increment) accesses the current pointer value and writes back that value plus one.
- R4: Mode 2 (pre-decrement) accesses the pointer value minus one and writes back that same value.
- R5: Mode 3 (displacement) accesses pointer plus the unsigned `req_disp` (0 to 63) when select is 1, 2 or 3, and does not write back. When select is 0 it ignores the offset and behaves as plain indirect.
- R6: Mode 4 (direct) accesses `req_imm` and does not write back. An immediate above 0x08FF raises no memory strobe and no load write.
- R7: Pointer arithmetic wraps modulo 2^16: 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.
- R8: A request accepted at a clock edge holds `busy`, `mem_en` and `mem_addr` for exactly the next cycle, with `mem_we` equal to `req_store`. `ptr_we` and `ld_we` appear in the cycle after that, while `busy` is low.
- R9: A request presented while `busy` is high is ignored and causes no access.
- R10: `ld_we` is high in the second cycle of an in-range load and never for a store. When a load writes back its pointer and `req_dst` is either byte of that pointer, the pointer write wins and `ld_we` stays low.
- R11: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_sel | input | 2 | Pointer select: 0, 1, 2 (3 acts as 2) |
| req_mode | input | 3 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement, 4 direct |
| req_disp | input | 6 | Unsigned displacement |
| req_imm | input | 16 | Direct address |
| req_store | input | 1 | 1 store, 0 load |
| req_dst | input | 5 | Load destination register |
| ptr_x | input | 16 | Current value of pair 27:26 |
| ptr_y | input | 16 | Current value of pair 29:28 |
| ptr_z | input | 16 | Current value of pair 31:30 |
| busy | output | 1 | First access cycle, stall |
| mem_en | output | 1 | Memory strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 16 | Effective address |
| ptr_we | output | 1 | Pointer pair write-back |
| ptr_lo_idx | output | 5 | Register taking the low byte |
| ptr_hi_idx | output | 5 | Register taking the high byte |
| ptr_lo_data | output | 8 | Low byte of the new pointer |
| ptr_hi_data | output | 8 | High byte of the new pointer |
| ld_we | output | 1 | Write the loaded byte |
| ld_idx | output | 5 | Register for the loaded byte |

## Verification
Every result has a fixed arrival cycle. The address, strobe and `busy` are due in the cycle after the edge that accepts the request, and the pointer write-back and load enable are due one cycle later. The scoreboard monitor waits for a rising `busy` and samples at the falling edge inside that cycle. It then advances exactly one more falling edge before it compares the second-cycle outputs, so each check reads the cycle in which its result is due. A request that must be ignored is detected by comparing the number of `busy` pulses with the number of expected items queued.

// File: rtl/ptr_agen_pkg.sv
package ptr_agen_pkg;
  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4
  } agen_mode_e;

  typedef enum logic [1:0] {
    PS_X = 2'd0,
    PS_Y = 2'd1,
    PS_Z = 2'd2
  } agen_ptr_e;

  localparam int unsigned NUM_PTR = 3;
endpackage

// File: rtl/agen_ptr_select.sv
module agen_ptr_select
  import ptr_agen_pkg::*;
#(
  parameter int AW      = 16,
  parameter int RF_DEPTH = 32,
  parameter int RIDX_W  = 5
) (
  input  logic [1:0]             sel,
  input  logic [NUM_PTR*AW-1:0]  ptrs_flat,
  output logic [AW-1:0]          ptr_val,
  output logic [RIDX_W-1:0]      lo_idx,
  output logic                   is_x
);
  localparam int BASE = RF_DEPTH - 2 * NUM_PTR;

  logic [AW-1:0]     ptr_tbl [NUM_PTR];
  logic [RIDX_W-1:0] idx_tbl [NUM_PTR];
  logic [1:0]        sel_c;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_pair
    assign ptr_tbl[g] = ptrs_flat[g*AW +: AW];
    assign idx_tbl[g] = RIDX_W'(BASE + 2 * g);
  end

  // select code 3 folds onto the last pointer
  assign sel_c   = (sel > 2'(NUM_PTR - 1)) ? 2'(NUM_PTR - 1) : sel;
  assign ptr_val = ptr_tbl[sel_c];
  assign lo_idx  = idx_tbl[sel_c];
  assign is_x    = (sel_c == PS_X);
endmodule

// File: rtl/agen_addr_calc.sv
module agen_addr_calc
  import ptr_agen_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DISP_W     = 6,
  parameter logic [15:0] DIRECT_MAX = 16'h08FF
) (
  input  logic [2:0]        mode,
  input  logic              is_x,
  input  logic [AW-1:0]     ptr,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     imm,
  output logic [AW-1:0]     eff_addr,
  output logic [AW-1:0]     new_ptr,
  output logic              wb_req,
  output logic              addr_ok
);
  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] p);
    return p - AW'(1);
  endfunction

  function automatic logic [AW-1:0] offset(input logic [AW-1:0] p,
                                           input logic [DISP_W-1:0] d);
    return p + AW'(d);
  endfunction

  always_comb begin
    eff_addr = ptr;
    new_ptr  = ptr;
    wb_req   = 1'b0;
    addr_ok  = 1'b1;
    case (agen_mode_e'(mode))
      AM_POSTINC: begin
        new_ptr = step_up(ptr);
        wb_req  = 1'b1;
      end
      AM_PREDEC: begin
        new_ptr  = step_down(ptr);
        eff_addr = new_ptr;
        wb_req   = 1'b1;
      end
      AM_DISP: begin
        if (!is_x) eff_addr = offset(ptr, disp);
      end
      AM_DIRECT: begin
        eff_addr = imm;
        addr_ok  = (imm <= AW'(DIRECT_MAX));
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/agen_phase.sv
module agen_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic accept,
  output logic ph_access,
  output logic ph_finish
);
  assign accept = req_valid && !ph_access;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_access <= 1'b0;
      ph_finish <= 1'b0;
    end else begin
      ph_access <= accept;
      ph_finish <= ph_access;
    end
  end
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_agen_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter int          AW         = 2 * BYTE_W,
  parameter int          DISP_W     = 6,
  parameter int          RF_DEPTH   = 32,
  parameter int          RIDX_W     = $clog2(RF_DEPTH),
  parameter logic [15:0] DIRECT_MAX = 16'h08FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_sel,
  input  logic [2:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [AW-1:0]     req_imm,
  input  logic              req_store,
  input  logic [RIDX_W-1:0] req_dst,
  input  logic [AW-1:0]     ptr_x,
  input  logic [AW-1:0]     ptr_y,
  input  logic [AW-1:0]     ptr_z,
  output logic              busy,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic              ptr_we,
  output logic [RIDX_W-1:0] ptr_lo_idx,
  output logic [RIDX_W-1:0] ptr_hi_idx,
  output logic [BYTE_W-1:0] ptr_lo_data,
  output logic [BYTE_W-1:0] ptr_hi_data,
  output logic              ld_we,
  output logic [RIDX_W-1:0] ld_idx
);
  logic              accept, ph_access, ph_finish;
  logic [AW-1:0]     sel_ptr, calc_addr, calc_new;
  logic [RIDX_W-1:0] sel_lo;
  logic              sel_is_x, calc_wb, calc_ok;

  logic [AW-1:0]     r_addr, r_new;
  logic [RIDX_W-1:0] r_lo, r_dst;
  logic              r_wb, r_ok, r_store;
  logic              dst_hits_ptr;

  agen_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .accept    (accept),
    .ph_access (ph_access),
    .ph_finish (ph_finish)
  );

  agen_ptr_select #(.AW(AW), .RF_DEPTH(RF_DEPTH), .RIDX_W(RIDX_W)) u_sel (
    .sel       (req_sel),
    .ptrs_flat ({ptr_z, ptr_y, ptr_x}),
    .ptr_val   (sel_ptr),
    .lo_idx    (sel_lo),
    .is_x      (sel_is_x)
  );

  agen_addr_calc #(.AW(AW), .DISP_W(DISP_W), .DIRECT_MAX(DIRECT_MAX)) u_calc (
    .mode     (req_mode),
    .is_x     (sel_is_x),
    .ptr      (sel_ptr),
    .disp     (req_disp),
    .imm      (req_imm),
    .eff_addr (calc_addr),
    .new_ptr  (calc_new),
    .wb_req   (calc_wb),
    .addr_ok  (calc_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_addr  <= '0;
      r_new   <= '0;
      r_lo    <= '0;
      r_dst   <= '0;
      r_wb    <= 1'b0;
      r_ok    <= 1'b0;
      r_store <= 1'b0;
    end else if (accept) begin
      r_addr  <= calc_addr;
      r_new   <= calc_new;
      r_lo    <= sel_lo;
      r_dst   <= req_dst;
      r_wb    <= calc_wb;
      r_ok    <= calc_ok;
      r_store <= req_store;
    end
  end

  // load destination overlaps the pointer being written back
  assign dst_hits_ptr = r_wb && (r_dst[RIDX_W-1:1] == r_lo[RIDX_W-1:1]);

  assign busy        = ph_access;
  assign mem_en      = ph_access && r_ok;
  assign mem_we      = ph_access && r_ok && r_store;
  assign mem_addr    = (ph_access && r_ok) ? r_addr : '0;
  assign ptr_we      = ph_finish && r_wb;
  assign ptr_lo_idx  = ptr_we ? r_lo : '0;
  assign ptr_hi_idx  = ptr_we ? (r_lo | RIDX_W'(1)) : '0;
  assign ptr_lo_data = ptr_we ? r_new[BYTE_W-1:0] : '0;
  assign ptr_hi_data = ptr_we ? r_new[AW-1:BYTE_W] : '0;
  assign ld_we       = ph_finish && r_ok && !r_store && !dst_hits_ptr;
  assign ld_idx      = ld_we ? r_dst : '0;
endmodule

// File: rtl/ptr_addr_gen_chk.sv
module ptr_addr_gen_chk #(
  parameter int AW     = 16,
  parameter int BYTE_W = 8,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_en,
  input logic [AW-1:0]     mem_addr,
  input logic              ptr_we,
  input logic [RIDX_W-1:0] ptr_lo_idx,
  input logic [RIDX_W-1:0] ptr_hi_idx,
  input logic [BYTE_W-1:0] ptr_lo_data,
  input logic [BYTE_W-1:0] ptr_hi_data,
  input logic              ld_we,
  input logic [RIDX_W-1:0] ld_idx,
  input logic              ph_finish
);
  // R8
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R8
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);

  // R8
  wb_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we || ld_we) |-> ($past(busy) && !busy && ph_finish));

  // R10
  load_yields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && ptr_we) |-> (ld_idx[RIDX_W-1:1] != ptr_lo_idx[RIDX_W-1:1]));

  // R1
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> (!ptr_lo_idx[0] && ptr_hi_idx == RIDX_W'(ptr_lo_idx + 1'b1)));

  // R3
  wb_near_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |-> ({ptr_hi_data, ptr_lo_data} == $past(mem_addr) ||
                {ptr_hi_data, ptr_lo_data} == AW'($past(mem_addr) + 1'b1)));
endmodule

bind ptr_addr_gen ptr_addr_gen_chk #(.AW(AW), .BYTE_W(BYTE_W), .RIDX_W(RIDX_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .mem_en      (mem_en),
  .mem_addr    (mem_addr),
  .ptr_we      (ptr_we),
  .ptr_lo_idx  (ptr_lo_idx),
  .ptr_hi_idx  (ptr_hi_idx),
  .ptr_lo_data (ptr_lo_data),
  .ptr_hi_data (ptr_hi_data),
  .ld_we       (ld_we),
  .ld_idx      (ld_idx),
  .ph_finish   (ph_finish)
);

// File: tb/ptr_addr_gen_tb_top.sv
module ptr_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [2:0]  req_mode = '0;
  logic [5:0]  req_disp = '0;
  logic [15:0] req_imm = '0;
  logic        req_store = 1'b0;
  logic [4:0]  req_dst = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic        busy, mem_en, mem_we, ptr_we, ld_we;
  logic [15:0] mem_addr;
  logic [4:0]  ptr_lo_idx, ptr_hi_idx, ld_idx;
  logic [7:0]  ptr_lo_data, ptr_hi_data;

  always #10 clk = ~clk;

  ptr_addr_gen dut_i (.*);

  typedef struct {
    string       tag;
    logic        en, we, pwe, lwe;
    logic [15:0] addr, nptr;
    logic [4:0]  lo, dst;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0, n_push = 0, n_busy = 0;
  bit   mon_on = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(string tag, logic [1:0] s, logic [2:0] m,
      logic [5:0] d, logic [15:0] imm, logic st, logic [4:0] dst,
      logic [15:0] px, logic [15:0] py, logic [15:0] pz);
    exp_t e;
    logic [15:0] p;
    logic ok, xsel;
    int base;
    xsel = (s == 2'd0);
    p    = xsel ? px : (s == 2'd1) ? py : pz;
    base = xsel ? 26 : (s == 2'd1) ? 28 : 30;
    e.tag = tag; e.pwe = 0; e.nptr = p; e.addr = p; ok = 1;
    if (m == 3'd1) begin e.pwe = 1; e.nptr = p + 16'd1; end
    else if (m == 3'd2) begin e.pwe = 1; e.nptr = p - 16'd1; e.addr = e.nptr; end
    else if (m == 3'd3) begin if (!xsel) e.addr = p + {10'd0, d}; end
    else if (m == 3'd4) begin e.addr = imm; ok = (imm < 16'h0900); end
    e.en  = ok;
    e.we  = ok && st;
    e.lo  = 5'(base);
    e.dst = dst;
    e.lwe = ok && !st && !(e.pwe && (int'(dst) == base || int'(dst) == base + 1));
    if (!ok) e.addr = 16'h0000;
    return e;
  endfunction

  // driver: called at a falling edge; returns two falling edges later
  task automatic issue(string tag, logic [1:0] s, logic [2:0] m, logic [5:0] d,
      logic [15:0] imm, logic st, logic [4:0] dst,
      logic [15:0] px, logic [15:0] py, logic [15:0] pz);
    req_valid = 1; req_sel = s; req_mode = m; req_disp = d; req_imm = imm;
    req_store = st; req_dst = dst; ptr_x = px; ptr_y = py; ptr_z = pz;
    exp_q.push_back(model(tag, s, m, d, imm, st, dst, px, py, pz));
    n_push++;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_on && busy) begin
        n_busy++;
        if (exp_q.size() == 0) begin
          chk("R9", "unexpected access", 32'(1), 32'(0));
        end else begin
          e = exp_q.pop_front();
          chk(e.tag, "mem_en", 32'(mem_en), 32'(e.en));
          chk(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
          chk(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
          @(negedge clk);
          chk(e.tag, "R8 busy 2nd", 32'(busy), 32'(0));
          chk(e.tag, "ptr_we", 32'(ptr_we), 32'(e.pwe));
          if (e.pwe) begin
            chk(e.tag, "R1 lo_idx", 32'(ptr_lo_idx), 32'(e.lo));
            chk(e.tag, "R1 hi_idx", 32'(ptr_hi_idx), 32'(e.lo + 5'd1));
            chk(e.tag, "new ptr", 32'({ptr_hi_data, ptr_lo_data}), 32'(e.nptr));
          end
          chk(e.tag, "R10 ld_we", 32'(ld_we), 32'(e.lwe));
          if (e.lwe) chk(e.tag, "ld_idx", 32'(ld_idx), 32'(e.dst));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "outputs in reset",
        32'({busy, mem_en, mem_we, ptr_we, ld_we, mem_addr}), 32'(0));
    rst_n = 1;
    mon_on = 1;
    @(negedge clk);

    issue("R2 plain X load", 2'd0, 3'd0, 6'd9, 16'h0, 0, 5'd5, 16'h1234, 16'h1, 16'h2);
    issue("R2 code7 Y load", 2'd1, 3'd7, 6'd0, 16'h0, 0, 5'd6, 16'h0, 16'h0456, 16'h2);
    issue("R3 postinc Y store", 2'd1, 3'd1, 6'd0, 16'h0, 1, 5'd0, 16'h0, 16'h0100, 16'h0);
    issue("R4 predec Z load", 2'd2, 3'd2, 6'd0, 16'h0, 0, 5'd3, 16'h0, 16'h0, 16'h0200);
    issue("R5 disp Y 63", 2'd1, 3'd3, 6'd63, 16'h0, 0, 5'd4, 16'h0, 16'h0300, 16'h0);
    issue("R5 disp Z 5 store", 2'd2, 3'd3, 6'd5, 16'h0, 1, 5'd0, 16'h0, 16'h0, 16'h07F0);
    issue("R5 disp X ignored", 2'd0, 3'd3, 6'd7, 16'h0, 0, 5'd8, 16'h0500, 16'h0, 16'h0);
    issue("R1 sel3 postinc", 2'd3, 3'd1, 6'd0, 16'h0, 1, 5'd0, 16'h0, 16'h0, 16'h0A0B);
    issue("R1 X postinc", 2'd0, 3'd1, 6'd0, 16'h0, 1, 5'd0, 16'h12FF, 16'h0, 16'h0);
    issue("R6 direct max", 2'd0, 3'd4, 6'd0, 16'h08FF, 0, 5'd9, 16'h0, 16'h0, 16'h0);
    issue("R6 direct over", 2'd0, 3'd4, 6'd0, 16'h0900, 0, 5'd9, 16'h0, 16'h0, 16'h0);
    issue("R6 direct store", 2'd2, 3'd4, 6'd0, 16'h0040, 1, 5'd0, 16'h0, 16'h0, 16'h0);
    issue("R7 postinc wrap", 2'd1, 3'd1, 6'd0, 16'h0, 0, 5'd2, 16'h0, 16'hFFFF, 16'h0);
    issue("R7 predec wrap", 2'd0, 3'd2, 6'd0, 16'h0, 0, 5'd2, 16'h0000, 16'h0, 16'h0);
    issue("R10 dst lo of X", 2'd0, 3'd1, 6'd0, 16'h0, 0, 5'd26, 16'h0040, 16'h0, 16'h0);
    issue("R10 dst hi of Z", 2'd2, 3'd2, 6'd0, 16'h0, 0, 5'd31, 16'h0, 16'h0, 16'h0041);
    issue("R10 dst outside", 2'd0, 3'd1, 6'd0, 16'h0, 0, 5'd25, 16'h0042, 16'h0, 16'h0);
    issue("R10 plain dst in X", 2'd0, 3'd0, 6'd0, 16'h0, 0, 5'd27, 16'h0043, 16'h0, 16'h0);

    // R9: second request held during the busy cycle must be dropped
    req_valid = 1; req_sel = 2'd1; req_mode = 3'd0; req_store = 0; req_dst = 5'd1;
    ptr_y = 16'h0600;
    exp_q.push_back(model("R9 first", 2'd1, 3'd0, 6'd0, 16'h0, 0, 5'd1,
                          16'h0, 16'h0600, 16'h0));
    n_push++;
    @(negedge clk);
    req_sel = 2'd2; req_mode = 3'd1; ptr_z = 16'h0777;
    @(negedge clk);
    req_valid = 0;
    repeat (4) @(negedge clk);

    // R8 back-to-back after an idle gap
    issue("R8 back1", 2'd2, 3'd1, 6'd0, 16'h0, 0, 5'd0, 16'h0, 16'h0, 16'h0010);
    issue("R8 back2", 2'd2, 3'd1, 6'd0, 16'h0, 0, 5'd0, 16'h0, 16'h0, 16'h0011);
    repeat (4) @(negedge clk);

    chk("R9", "access count", 32'(n_busy), 32'(n_push));
    chk("R9", "queue empty", 32'(exp_q.size()), 32'(0));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule